// File: doc/BRIEF.md
# Reversible Counter with Selectable End Behaviour

This block is a small synchronous counter whose value moves by one on every clock edge. One control input chooses whether it climbs or falls. A second control input chooses what happens at the ends of the range.

In the first end policy the count rolls over to the opposite end. In the second it clamps and stays at the end it has reached. Both controls are runtime inputs, so software-free control logic can switch direction or policy between any two edges.

The width is a parameter with a default of 3 bits, so the default range is 0 to 7. The clamp limits are always the all-zeros and all-ones values for the chosen width. The count comes straight from a register. A synchronous active-high reset clears it.

Top module: `updn_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `count` reads 0 after that edge, whatever the other inputs are.
- R2: With `dir_down` = 0 and `count` below the all-ones value, each edge raises `count` by exactly one.
- R3: With `dir_down` = 1 and `count` above zero, each edge lowers `count` by exactly one.
- R4: With `dir_down` = 0, `hold_ends` = 0 (roll-over policy) and `count` at all-ones (7 for the default width), the next edge gives 0.
- R5: With `dir_down` = 1, `hold_ends` = 0 and `count` at 0, the next edge gives all-ones (7 for the default width).
- R6: With `dir_down` = 0, `hold_ends` = 1 (clamp policy) and `count` at all-ones, `count` stays at all-ones for every further edge.
- R7: With `dir_down` = 1, `hold_ends` = 1 and `count` at 0, `count` stays at 0 for every further edge.
- R8: `dir_down` and `hold_ends` are sampled only at the rising edge. A change between edges alters the step of the next edge, and that step starts from the value `count` holds at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| dir_down | input | 1 | 0 counts upward, 1 counts downward |
| hold_ends | input | 1 | 0 rolls over at the range ends, 1 clamps at them |
| count | output | WIDTH | Registered count value |

## Verification
On every cycle out of reset, the embedded assertions check these behaviours:
- the single-step rise and fall away from the ends;
- the roll-over at each end under the roll-over policy;
- the hold at each end under the clamp policy;
- the clear that follows a reset.

Only the bench scenarios can show the following:
- long runs of repeated clamping at an end;
- switching direction or policy between edges and resuming from the current value;
- reset landing in the middle of a count.

The bench reaches these through a sweep that covers every start value under all four control combinations.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;

  typedef enum logic {
    POLICY_WRAP  = 1'b0,
    POLICY_CLAMP = 1'b1
  } end_policy_e;
endpackage

// File: rtl/updn_ends.sv
module updn_ends #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] value,
  output logic             at_top,
  output logic             at_bottom
);
  // Range limits are the all-ones and all-zeros codes of the width.
  assign at_top    = &value;
  assign at_bottom = ~|value;
endmodule

// File: rtl/updn_step.sv
module updn_step #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0]          cur,
  input  updn_pkg::dir_e            dir,
  input  updn_pkg::end_policy_e     policy,
  input  logic                      at_top,
  input  logic                      at_bottom,
  output logic [WIDTH-1:0]          next_val
);
  import updn_pkg::*;

  localparam logic [WIDTH-1:0] STEP    = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  always_comb begin
    next_val = cur;
    unique case (dir)
      DIR_UP: begin
        if (at_top) next_val = (policy == POLICY_CLAMP) ? TOP_VAL : BOT_VAL;
        else        next_val = cur + STEP;
      end
      DIR_DOWN: begin
        if (at_bottom) next_val = (policy == POLICY_CLAMP) ? BOT_VAL : TOP_VAL;
        else           next_val = cur - STEP;
      end
      default: next_val = cur;
    endcase
  end
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_down,
  input  logic             hold_ends,
  output logic [WIDTH-1:0] count
);
  import updn_pkg::*;

  localparam logic [WIDTH-1:0] TOP_VAL = '1;
  localparam logic [WIDTH-1:0] BOT_VAL = '0;
  localparam logic [WIDTH-1:0] STEP    = WIDTH'(1);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic             at_top;
  logic             at_bottom;
  dir_e             dir_sel;
  end_policy_e      policy_sel;

  assign dir_sel    = dir_e'(dir_down);
  assign policy_sel = end_policy_e'(hold_ends);

  updn_ends #(.WIDTH(WIDTH)) u_ends (
    .value     (count_q),
    .at_top    (at_top),
    .at_bottom (at_bottom)
  );

  updn_step #(.WIDTH(WIDTH)) u_step (
    .cur       (count_q),
    .dir       (dir_sel),
    .policy    (policy_sel),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .next_val  (count_d)
  );

  always_ff @(posedge clk) begin
    if (rst) count_q <= BOT_VAL;
    else     count_q <= count_d;
  end

  assign count = count_q;

  // R1: reset clears on the following edge
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count == BOT_VAL));

  // R2: single upward step away from the top
  a_r2_up_step: assert property (@(posedge clk) disable iff (rst)
    (!dir_down && count != TOP_VAL) |=> (count == WIDTH'($past(count) + STEP)));

  // R3: single downward step away from the bottom
  a_r3_down_step: assert property (@(posedge clk) disable iff (rst)
    (dir_down && count != BOT_VAL) |=> (count == WIDTH'($past(count) - STEP)));

  // R4: roll over from top to zero
  a_r4_wrap_top: assert property (@(posedge clk) disable iff (rst)
    (!dir_down && !hold_ends && count == TOP_VAL) |=> (count == BOT_VAL));

  // R5: roll over from zero to top
  a_r5_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
    (dir_down && !hold_ends && count == BOT_VAL) |=> (count == TOP_VAL));

  // R6: clamp at top
  a_r6_clamp_top: assert property (@(posedge clk) disable iff (rst)
    (!dir_down && hold_ends && count == TOP_VAL) |=> $stable(count));

  // R7: clamp at bottom
  a_r7_clamp_bottom: assert property (@(posedge clk) disable iff (rst)
    (dir_down && hold_ends && count == BOT_VAL) |=> $stable(count));
endmodule

// File: tb/tb_updn_counter.sv
`timescale 1ns/1ps
module tb_updn_counter;
  localparam int WIDTH = 3;
  localparam int MAXV  = (1 << WIDTH) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             dir_down = 1'b0;
  logic             hold_ends = 1'b0;
  logic [WIDTH-1:0] count;

  int total = 0;
  int bad   = 0;
  int exp_v = 0;
  int cycles = 0;

  updn_counter #(.WIDTH(WIDTH)) dut (
    .clk       (clk),
    .rst       (rst),
    .dir_down  (dir_down),
    .hold_ends (hold_ends),
    .count     (count)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog expired, all requirements unverified: actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag);
    total = total + 1;
    if (int'(count) != exp_v) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, count, exp_v);
    end
  endtask

  // One clock with the given controls; expected value computed arithmetically.
  task automatic step(input logic d, input logic m, input logic r);
    string tag;
    dir_down  = d;
    hold_ends = m;
    rst       = r;
    if (r) begin
      tag = "R1"; exp_v = 0;
    end else if (!d) begin
      if (exp_v < MAXV) begin tag = "R2"; exp_v = exp_v + 1; end
      else if (!m)      begin tag = "R4"; exp_v = 0; end
      else              begin tag = "R6"; end
    end else begin
      if (exp_v > 0)    begin tag = "R3"; exp_v = exp_v - 1; end
      else if (!m)      begin tag = "R5"; exp_v = MAXV; end
      else              begin tag = "R7"; end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    // R1: reset state
    step(1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);

    // All four combinations, long runs to hit ends repeatedly (R2..R7)
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 3 * (MAXV + 1); k++)
        step(c[0], c[1], 1'b0);
    end

    // Exhaustive: every start value under every combination
    for (int s = 0; s <= MAXV; s++) begin
      for (int c = 0; c < 4; c++) begin
        step(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < s; k++) step(1'b0, 1'b0, 1'b0);
        step(c[0], c[1], 1'b0);
        step(c[0], c[1], 1'b0);
      end
    end

    // R8: controls changing between edges, resuming from the current value
    step(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 40; k++)
      step(k[0] ^ k[2], k[1], 1'b0);

    // R1: reset in mid-count, then resume upward
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule